// File: doc/BRIEF.md
# Quasi-Cyclic Repeat-Accumulate Parity Encoder

This block computes the parity part of a codeword for a repeat-accumulate low-density parity-check code with quasi-cyclic structure. Information bits arrive one at a time. They are handled in groups of `GRP` consecutive bits, and each group has a few base check indices that come from an external table. The table is read through a combinational ROM port. Every information bit is XOR-folded into a parity store of `q_max` rows by `GRP` columns, one check address per clock cycle. While this read-modify-write work runs, the serial input is held off.

When the last information bit has been absorbed, the block walks the parity store column by column across the first `q` rows, eight stored bits per cycle. It runs the accumulator chain over them and emits the finished parity bits one byte per cycle. The last parity bit of each byte is carried into the next byte. A start pulse with a two-bit rate code selects one of four reduced code options and clears both the store and the carry.

Top module: `qc_ira_ldpc_enc`

## Requirements
- R1: While reset is held and just after it is released, `in_rdy`, `par_vld` and `par_last` are 0.
- R2: A `start` pulse while idle selects a code option from `rate`, clears the parity store and the accumulator carry, and raises `in_rdy` from the next cycle onward. The options map rate code to (info groups kg, rows q) as 0→(2,6), 1→(3,5), 2→(4,4), 3→(6,3). The parity length is q·GRP.
- R3: For slot w of group g, `rom_addr` = (rate·GMAX + g)·NW + w. The `rom_idx` value returned in the same cycle is used as the base index c of that slot.
- R4: Information bit t (0-based) of group g is XORed into parity position (c + t·q) mod (q·GRP) for each of its NW base indices c.
- R5: After an accepted bit (`in_vld` and `in_rdy` at an edge), `in_rdy` is low for exactly NW cycles and then returns high, unless that bit was the last one.
- R6: The first parity byte appears with `par_vld` NW+1 cycles after the edge that accepted the last information bit. The remaining bytes follow on consecutive cycles, q·GRP/8 bytes in all.
- R7: Byte b, bit k (bit 0 first) is parity p(8b+k), where p(j) = s(j) XOR p(j−1), p(−1) = 0, and s(j) is accumulated parity position j.
- R8: `par_last` is high together with the final byte only. In the cycle after it, `par_vld` and `in_rdy` are 0.
- R9: A `start` pulse while a codeword is in progress has no effect on the emitted bytes.
- R10: `in_vld` and `in_bit` are ignored while `in_rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a codeword (accepted when idle) |
| rate | input | 2 | Code option select |
| in_vld | input | 1 | Information bit valid |
| in_bit | input | 1 | Information bit |
| in_rdy | output | 1 | Block can take an information bit |
| rom_addr | output | 7 | Base-index table address |
| rom_idx | input | 12 | Base index read from the table |
| par_vld | output | 1 | Parity byte valid |
| par_byte | output | 8 | Eight parity bits, earliest in bit 0 |
| par_last | output | 1 | Final parity byte of the codeword |

## Verification
The bench runs every code option. It uses all-ones data, alternating data, pseudo-random data, and a single set bit. The single set bit exposes each check address on its own, so a wrong row, a wrong column rotation or a wrong ROM slot shows up directly. Dense patterns expose the carry handoff between bytes and any clearing fault left over from the previous codeword. One pseudo-random run adds input gaps, garbage bits offered while the input is stalled, and a stray start pulse mid-codeword. Its byte stream must still match the model.

// File: rtl/qc_ira_pkg.sv
package qc_ira_pkg;

  localparam int RATE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FEED,
    ST_UPD,
    ST_EMIT
  } st_e;

  // rows of the parity store used by a code option
  function automatic int cfg_q(input logic [RATE_W-1:0] r);
    case (r)
      2'd0:    return 6;
      2'd1:    return 5;
      2'd2:    return 4;
      default: return 3;
    endcase
  endfunction

  // information groups of a code option
  function automatic int cfg_kg(input logic [RATE_W-1:0] r);
    case (r)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction

  // flat table slot of (option, group, slot)
  function automatic int rom_slot(input int r, input int g, input int w,
                                  input int gmax, input int nw);
    return (r * gmax + g) * nw + w;
  endfunction

endpackage

// File: rtl/qc_addr_gen.sv
module qc_addr_gen #(
  parameter int GRP  = 360,
  parameter int QMAX = 6,
  parameter int IW   = 12,
  parameter int QW   = 3,
  parameter int RW   = 3,
  parameter int CW   = 9
) (
  input  logic [IW-1:0] base_idx,
  input  logic [CW-1:0] tpos,
  input  logic [QW-1:0] q,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);
  // position a = c + t*q keeps row c mod q; the column rotates by t
  always_comb begin
    int qq;
    int ci;
    int cc;
    qq  = (q == '0) ? 1 : int'(q);
    ci  = int'(base_idx);
    row = RW'(ci % qq);
    cc  = ci / qq + int'(tpos);
    if (cc >= GRP) cc = cc - GRP;
    col = CW'(cc);
  end
endmodule

// File: rtl/qc_parity_mem.sv
module qc_parity_mem #(
  parameter int GRP  = 360,
  parameter int QMAX = 6,
  parameter int OB   = 8,
  parameter int QW   = 3,
  parameter int RW   = 3,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd_en,
  input  logic [RW-1:0] upd_row,
  input  logic [CW-1:0] upd_col,
  input  logic          upd_bit,
  input  logic [QW-1:0] q,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [OB-1:0] rd_bits,
  output logic [RW-1:0] nx_row,
  output logic [CW-1:0] nx_col
);
  logic [GRP-1:0] rows [QMAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QMAX; i++) rows[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < QMAX; i++) rows[i] <= '0;
    end else if (upd_en) begin
      rows[upd_row][upd_col] <= rows[upd_row][upd_col] ^ upd_bit;
    end
  end

  // column-wise walk: down the first q rows, then next column
  always_comb begin
    logic [RW-1:0] r;
    logic [CW-1:0] c;
    r = rd_row;
    c = rd_col;
    for (int k = 0; k < OB; k++) begin
      rd_bits[k] = rows[r][c];
      if (QW'(r) == q - QW'(1)) begin
        r = '0;
        c = c + CW'(1);
      end else begin
        r = r + RW'(1);
      end
    end
    nx_row = r;
    nx_col = c;
  end

  // R4: every update lands inside the column range
  a_r4_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (upd_col < CW'(GRP)));

endmodule

// File: rtl/qc_accum.sv
module qc_accum #(
  parameter int OB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          last_in,
  input  logic [OB-1:0] bits,
  output logic          par_vld,
  output logic [OB-1:0] par_byte,
  output logic          par_last
);
  logic          carry;
  logic [OB-1:0] nxt;

  always_comb begin
    logic a;
    a = carry;
    for (int k = 0; k < OB; k++) begin
      a      = a ^ bits[k];
      nxt[k] = a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry    <= 1'b0;
      par_vld  <= 1'b0;
      par_byte <= '0;
      par_last <= 1'b0;
    end else begin
      par_vld  <= en;
      par_last <= en & last_in;
      if (clr) begin
        carry <= 1'b0;
      end else if (en) begin
        par_byte <= nxt;
        carry    <= nxt[OB-1];
      end
    end
  end

  // R8: the final marker never stands alone
  a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    par_last |-> par_vld);

endmodule

// File: rtl/qc_ira_ldpc_enc.sv
module qc_ira_ldpc_enc
  import qc_ira_pkg::*;
#(
  parameter int GRP  = 360,
  parameter int QMAX = 6,
  parameter int GMAX = 6,
  parameter int NW   = 3,
  parameter int OB   = 8,
  localparam int IW  = $clog2(QMAX * GRP),
  localparam int AW  = $clog2((1 << RATE_W) * GMAX * NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  input  logic              in_vld,
  input  logic              in_bit,
  output logic              in_rdy,
  output logic [AW-1:0]     rom_addr,
  input  logic [IW-1:0]     rom_idx,
  output logic              par_vld,
  output logic [OB-1:0]     par_byte,
  output logic              par_last
);
  localparam int QW  = $clog2(QMAX + 1);
  localparam int RW  = (QMAX > 1) ? $clog2(QMAX) : 1;
  localparam int CW  = $clog2(GRP + 1);
  localparam int KW  = $clog2(GMAX + 1);
  localparam int SW  = (NW > 1) ? $clog2(NW) : 1;
  localparam int BCW = $clog2(QMAX * GRP / OB + 1);

  st_e               st;
  logic [RATE_W-1:0] rate_q;
  logic [QW-1:0]     q_q;
  logic [KW-1:0]     kg_q, g_q;
  logic [CW-1:0]     t_q;
  logic [SW-1:0]     w_q;
  logic              bit_q;
  logic [RW-1:0]     rd_row, nx_row, upd_row;
  logic [CW-1:0]     rd_col, nx_col, upd_col;
  logic [BCW-1:0]    left_q;
  logic [OB-1:0]     col_bits;

  // named internal events
  wire start_ok = (st == ST_IDLE) && start;
  wire upd_en   = (st == ST_UPD);
  wire emit_en  = (st == ST_EMIT);
  wire slot_end = (w_q == SW'(NW - 1));
  wire grp_end  = (t_q == CW'(GRP - 1));
  wire word_end = (g_q == kg_q - KW'(1));
  wire emit_end = (left_q == BCW'(1));

  assign in_rdy   = (st == ST_FEED);
  assign rom_addr = AW'(rom_slot(int'(rate_q), int'(g_q), int'(w_q), GMAX, NW));

  qc_addr_gen #(.GRP(GRP), .QMAX(QMAX), .IW(IW), .QW(QW), .RW(RW), .CW(CW)) u_addr (
    .base_idx(rom_idx), .tpos(t_q), .q(q_q), .row(upd_row), .col(upd_col)
  );

  qc_parity_mem #(.GRP(GRP), .QMAX(QMAX), .OB(OB), .QW(QW), .RW(RW), .CW(CW)) u_mem (
    .clk(clk), .rst_n(rst_n), .clr(start_ok),
    .upd_en(upd_en), .upd_row(upd_row), .upd_col(upd_col), .upd_bit(bit_q),
    .q(q_q), .rd_row(rd_row), .rd_col(rd_col),
    .rd_bits(col_bits), .nx_row(nx_row), .nx_col(nx_col)
  );

  qc_accum #(.OB(OB)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(emit_en), .last_in(emit_end),
    .bits(col_bits), .par_vld(par_vld), .par_byte(par_byte), .par_last(par_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rate_q <= '0;
      q_q    <= '0;
      kg_q   <= '0;
      g_q    <= '0;
      t_q    <= '0;
      w_q    <= '0;
      bit_q  <= 1'b0;
      rd_row <= '0;
      rd_col <= '0;
      left_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          rate_q <= rate;
          q_q    <= QW'(cfg_q(rate));
          kg_q   <= KW'(cfg_kg(rate));
          g_q    <= '0;
          t_q    <= '0;
          w_q    <= '0;
          rd_row <= '0;
          rd_col <= '0;
          left_q <= BCW'(cfg_q(rate) * GRP / OB);
          st     <= ST_FEED;
        end
        ST_FEED: if (in_vld) begin
          bit_q <= in_bit;
          w_q   <= '0;
          st    <= ST_UPD;
        end
        ST_UPD: begin
          if (slot_end) begin
            w_q <= '0;
            if (grp_end) begin
              t_q <= '0;
              if (word_end) begin
                st <= ST_EMIT;
              end else begin
                g_q <= g_q + KW'(1);
                st  <= ST_FEED;
              end
            end else begin
              t_q <= t_q + CW'(1);
              st  <= ST_FEED;
            end
          end else begin
            w_q <= w_q + SW'(1);
          end
        end
        ST_EMIT: begin
          rd_row <= nx_row;
          rd_col <= nx_col;
          left_q <= left_q - BCW'(1);
          if (emit_end) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: an accepted bit stalls the input in the next cycle
  a_r5_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy && in_vld) |=> !in_rdy);

  // R2: an idle start opens the input one cycle later
  a_r2_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> in_rdy);

  // R10: no input is taken while bytes are leaving
  a_r10_no_input_during_emit: assert property (@(posedge clk) disable iff (!rst_n)
    par_vld |-> !in_rdy);

  // R4: the address generator keeps rows inside the selected option
  a_r4_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (QW'(upd_row) < q_q));

  // R9: a start pulse mid-codeword leaves the option unchanged
  a_r9_option_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != ST_IDLE) && start) |=> $stable(q_q));

endmodule

// File: tb/qc_ira_ldpc_enc_tb.sv
`timescale 1ns/1ps
module qc_ira_ldpc_enc_tb;
  localparam int GRP  = 360;
  localparam int QMAX = 6;
  localparam int GMAX = 6;
  localparam int NW   = 3;
  localparam int OB   = 8;
  localparam int IW   = $clog2(QMAX * GRP);
  localparam int AW   = $clog2(4 * GMAX * NW);

  logic          clk = 1'b0;
  logic          rst_n, start, in_vld, in_bit, in_rdy;
  logic [1:0]    rate;
  logic [AW-1:0] rom_addr;
  logic [IW-1:0] rom_idx;
  logic          par_vld, par_last;
  logic [OB-1:0] par_byte;

  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  function automatic int tb_q(input int r);
    if (r == 0) return 6;
    if (r == 1) return 5;
    if (r == 2) return 4;
    return 3;
  endfunction

  function automatic int tb_kg(input int r);
    if (r == 0) return 2;
    if (r == 1) return 3;
    if (r == 2) return 4;
    return 6;
  endfunction

  // the bench's own reduced base-index table
  function automatic int tb_rom(input int a);
    int r;
    r = a / (GMAX * NW);
    return (a * 571 + r * 37 + 13) % (tb_q(r) * GRP);
  endfunction

  assign rom_idx = IW'(tb_rom(int'(rom_addr)));

  qc_ira_ldpc_enc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate(rate),
    .in_vld(in_vld), .in_bit(in_bit), .in_rdy(in_rdy),
    .rom_addr(rom_addr), .rom_idx(rom_idx),
    .par_vld(par_vld), .par_byte(par_byte), .par_last(par_last)
  );

  task automatic check(input bit ok, input string req, input int got, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, expv);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog got=%0d exp=0", cyc);
        summary();
      end
    end
  end

  bit info [QMAX*GRP];
  bit sv   [QMAX*GRP];
  logic [7:0] expq [$];

  task automatic build(input int rt, input int pat);
    int q, kg, nb, m, acc;
    q  = tb_q(rt);
    kg = tb_kg(rt);
    nb = kg * GRP;
    m  = q * GRP;
    for (int i = 0; i < QMAX * GRP; i++) begin
      sv[i] = 1'b0;
      case (pat)
        0:       info[i] = 1'b1;
        2:       info[i] = bit'(i % 2);
        3:       info[i] = (i == nb / 2 + 7);
        default: info[i] = bit'($urandom % 2);
      endcase
    end
    // R4: fold every bit into its NW positions
    for (int g = 0; g < kg; g++)
      for (int t = 0; t < GRP; t++)
        for (int w = 0; w < NW; w++) begin
          int c;
          c = tb_rom((rt * GMAX + g) * NW + w);
          if (info[g * GRP + t]) sv[(c + t * q) % m] ^= 1'b1;
        end
    // R7: running accumulation packed eight to a byte
    expq.delete();
    acc = 0;
    for (int b = 0; b < m / 8; b++) begin
      logic [7:0] v;
      for (int k = 0; k < 8; k++) begin
        acc  = acc ^ int'(sv[8 * b + k]);
        v[k] = acc[0];
      end
      expq.push_back(v);
    end
  endtask

  task automatic run(input int rt, input int pat);
    int nbits, nbytes, idx, got, lowcnt, since;
    bit seen_acc, done_in, first;
    string tag;
    build(rt, pat);
    nbits  = tb_kg(rt) * GRP;
    nbytes = tb_q(rt) * GRP / 8;
    tag    = (pat == 4) ? "R7 R9 R10 byte" : "R7 R3 R4 R10 byte";
    @(negedge clk);
    start = 1'b1;
    rate  = 2'(rt);
    @(negedge clk);
    start = 1'b0;
    check(in_rdy == 1'b1, "R2 ready after start", int'(in_rdy), 1);
    check(int'(rom_addr) == rt * GMAX * NW, "R3 first table slot", int'(rom_addr), rt * GMAX * NW);
    idx = 0; got = 0; lowcnt = 0; since = 0;
    seen_acc = 0; done_in = 0; first = 1;
    while (got < nbytes) begin
      if (done_in) since++;
      if (par_vld) begin
        if (first) check(since == NW + 2, "R6 first byte timing", since, NW + 2);
        first = 0;
        check(par_byte == expq[got], tag, int'(par_byte), int'(expq[got]));
        check(par_last == (got == nbytes - 1), "R8 last flag", int'(par_last),
              int'(got == nbytes - 1));
        got++;
      end else if (!first) begin
        check(1'b0, "R6 gap in byte stream", 0, 1);
      end
      if (in_rdy) begin
        if (seen_acc) check(lowcnt == NW, "R5 stall length", lowcnt, NW);
        lowcnt   = 0;
        seen_acc = 0;
      end else if (seen_acc) begin
        lowcnt++;
      end
      start = 1'b0;
      if (pat == 4 && idx == 100 && in_rdy) begin
        start = 1'b1;
        rate  = 2'd3;
      end
      if (in_rdy && idx < nbits) begin
        if (pat == 4 && ($urandom % 4) == 0) begin
          in_vld = 1'b0;
          in_bit = 1'b1;
        end else begin
          in_vld   = 1'b1;
          in_bit   = info[idx];
          idx++;
          seen_acc = 1;
          if (idx == nbits) done_in = 1;
        end
      end else begin
        in_vld = 1'b1;
        in_bit = 1'($urandom);
      end
      @(negedge clk);
    end
    in_vld = 1'b0;
    start  = 1'b0;
    check(par_vld == 1'b0, "R8 valid drops after last", int'(par_vld), 0);
    check(in_rdy == 1'b0, "R8 idle after last", int'(in_rdy), 0);
  endtask

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    rate   = 2'd0;
    in_vld = 1'b0;
    in_bit = 1'b0;
    repeat (3) @(negedge clk);
    check(in_rdy == 1'b0, "R1 in_rdy in reset", int'(in_rdy), 0);
    check(par_vld == 1'b0, "R1 par_vld in reset", int'(par_vld), 0);
    check(par_last == 1'b0, "R1 par_last in reset", int'(par_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_rdy == 1'b0, "R1 idle after reset", int'(in_rdy), 0);
    run(0, 0);
    run(1, 1);
    run(2, 2);
    run(3, 3);
    run(2, 0);
    run(0, 4);
    run(3, 1);
    summary();
  end
endmodule